// File: doc/BRIEF.md
# External Bus Arbiter with SDRAM Refresh and Bus Hold

This block sits at the front of an external memory controller. Each clock cycle it picks at most one command for the memory sequencer. The choice is made among three kinds of demand. Internal requesters (processor and transfer engines) ask for read or write access to a chip-enable space and a row. The SDRAM needs periodic refresh. An external master may ask to take the bus through a hold request.

The arbiter remembers, for every chip-enable space, whether a row is open and which one. An access whose row is not open gets an activate before its read/write. Every close-all command invalidates the memory of all spaces together, whether a refresh or a mode-register update caused it.

Refresh is timed by a free-running counter that is compared against a period input. A first expiry makes the refresh pending, and the refresh waits politely for the current owner. A second expiry makes it urgent, and it then takes the next command slot. The hold request is sampled as a level and gated by a mask input. Before the bus is handed over, the SDRAM is always closed and refreshed.

Top module: `ext_bus_arbiter`

## Requirements
- R1: A granted access whose space has no open row, or has a different open row, issues activate (cmd 1) and then read/write (cmd 2). An access to the row already open in its space issues read/write directly. Each space keeps its own open row.
- R2: After a close-all (cmd 3), the next access to any space issues activate first, even when it targets the row that was open before.
- R3: With no requester active, a refresh is a close-all followed by a refresh command (cmd 4). Between two such refreshes there are period+2 cycles, and the first refresh after reset comes at cycle period+2.
- R4: A pending refresh waits while the owner keeps requesting. When the period expires a second time, the refresh becomes urgent and the close-all is issued on the next cycle, even though the owner is still requesting.
- R5: A close-all occupies exactly one cycle and is always followed directly by a refresh or a mode-register command.
- R6: A one-cycle mode request leads, once the bus is free, to a close-all and then a mode-register command (cmd 5).
- R7: While the hold mask is high, a hold request is ignored: hold_ack stays low and refreshes continue at the normal interval.
- R8: Clearing the mask while the hold request is still high causes a close-all on the next cycle, then a refresh. hold_ack rises in the same cycle as that refresh, with no new edge on the hold request.
- R9: While hold_ack is high, the command is NOP (cmd 0) and no grant is given.
- R10: hold_ack falls on the first clock edge that samples the hold request low. Requests are served again on the following cycle.
- R11: A lower requester index has higher priority. An owner that keeps requesting holds the bus for a burst of BURST read/writes. At that boundary it yields to a higher-priority requester.
- R12: After reset, cmd is NOP and gnt and hold_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NREQ | Access request level per requester |
| req_ce | input | NREQ*CEW | Chip-enable space per requester |
| req_row | input | NREQ*ROWW | Row per requester |
| mode_req | input | 1 | One-cycle pulse asking for a mode-register update |
| hold_req | input | 1 | External bus hold request, level |
| hold_mask | input | 1 | When high, hold requests are ignored |
| ref_period | input | PW | Refresh interval in cycles |
| gnt | output | NREQ | One-hot grant for the command in this cycle |
| cmd | output | 3 | 0 NOP, 1 activate, 2 read/write, 3 close-all, 4 refresh, 5 mode-register |
| cmd_ce | output | CEW | Space of an activate or read/write |
| cmd_row | output | ROWW | Row of an activate or read/write |
| hold_ack | output | 1 | Bus handed to the external holder |

## Verification
The hardest case to reach is a refresh escalating to urgent while an owner never lets go of the bus. It needs two full counter expiries with the trickle refresh held back in between. The stimulus keeps one requester asserted from reset with a short period and expects the close-all exactly one cycle after the second expiry. It then expects an activate for the unchanged row. A second hard case is the unmask-while-held path. The bench holds the request with the mask set across three refresh intervals, counts the refreshes, and then clears only the mask.

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
  parameter int NREQ  = 2,
  parameter int NCE   = 4,
  parameter int ROWW  = 4,
  parameter int BURST = 4,
  parameter int PW    = 10,
  localparam int CEW  = (NCE > 1) ? $clog2(NCE) : 1,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int BW   = $clog2(BURST + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req,
  input  logic [NREQ*CEW-1:0]  req_ce,
  input  logic [NREQ*ROWW-1:0] req_row,
  input  logic                 mode_req,
  input  logic                 hold_req,
  input  logic                 hold_mask,
  input  logic [PW-1:0]        ref_period,
  output logic [NREQ-1:0]      gnt,
  output logic [2:0]           cmd,
  output logic [CEW-1:0]       cmd_ce,
  output logic [ROWW-1:0]      cmd_row,
  output logic                 hold_ack
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RW = 3'd2,
                         C_DCA = 3'd3, C_REF = 3'd4, C_MRS = 3'd5;
  localparam logic [1:0] S_RUN = 2'd0, S_SEQ = 2'd1, S_HOLD = 2'd2;

  logic [1:0]      st;
  logic [PW-1:0]   cnt;
  logic            pend, urg, mpend, go_mrs, own_v;
  logic [IW-1:0]   own, pick, sel;
  logic [BW-1:0]   beat, base;
  logic [NCE-1:0]  pg_v;
  logic [ROWW-1:0] pg_row [NCE];

  logic [PW:0]     nxt;
  logic [NREQ-1:0] hmask;
  logic            tick, own_act, want_hold, burst_done, higher, keep, any, hit, start_seq;
  logic [CEW-1:0]  sce;
  logic [ROWW-1:0] srow;

  assign nxt        = {1'b0, cnt} + 1'b1;
  assign tick       = nxt >= {1'b0, ref_period};
  assign own_act    = own_v & req[own];
  assign want_hold  = hold_req & ~hold_mask;
  assign burst_done = beat >= BW'(BURST);
  assign hmask      = (NREQ'(1) << own) - NREQ'(1);
  assign higher     = |(req & hmask);
  assign keep       = own_act & ~(burst_done & higher);
  assign sel        = keep ? own : pick;
  assign any        = keep | (|req);
  assign sce        = req_ce[int'(sel)*CEW +: CEW];
  assign srow       = req_row[int'(sel)*ROWW +: ROWW];
  assign hit        = pg_v[sce] && (pg_row[sce] == srow);
  assign start_seq  = urg | (~own_act & (pend | want_hold | mpend));
  assign base       = (keep && !burst_done) ? beat : '0;

  always_comb begin
    pick = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req[i]) pick = IW'(i);
  end

  wire ref_now = (st == S_SEQ) && !go_mrs;
  wire mrs_now = (st == S_SEQ) && go_mrs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN; cnt <= '0; pend <= 1'b0; urg <= 1'b0; mpend <= 1'b0;
      go_mrs <= 1'b0; own_v <= 1'b0; own <= '0; beat <= '0; pg_v <= '0;
      for (int i = 0; i < NCE; i++) pg_row[i] <= '0;
      gnt <= '0; cmd <= C_NOP; cmd_ce <= '0; cmd_row <= '0; hold_ack <= 1'b0;
    end else begin
      if (ref_now || tick) cnt <= '0;
      else                 cnt <= nxt[PW-1:0];
      if (ref_now) begin
        pend <= 1'b0; urg <= 1'b0;
      end else if (tick) begin
        pend <= 1'b1; urg <= urg | pend;
      end
      if (mrs_now)  mpend <= 1'b0;
      if (mode_req) mpend <= 1'b1;

      cmd <= C_NOP;
      gnt <= '0;
      case (st)
        S_RUN: begin
          if (start_seq) begin
            cmd    <= C_DCA;
            pg_v   <= '0;
            own_v  <= 1'b0;
            st     <= S_SEQ;
            go_mrs <= ~urg & ~pend & ~want_hold & mpend;
          end else if (any) begin
            gnt     <= NREQ'(1) << sel;
            own     <= sel;
            own_v   <= 1'b1;
            cmd_ce  <= sce;
            cmd_row <= srow;
            if (hit) begin
              cmd  <= C_RW;
              beat <= base + 1'b1;
            end else begin
              cmd         <= C_ACT;
              beat        <= base;
              pg_v[sce]   <= 1'b1;
              pg_row[sce] <= srow;
            end
          end else begin
            own_v <= 1'b0;
          end
        end
        S_SEQ: begin
          cmd <= go_mrs ? C_MRS : C_REF;
          if (!go_mrs && want_hold) begin
            st <= S_HOLD; hold_ack <= 1'b1;
          end else begin
            st <= S_RUN;
          end
        end
        default: begin
          if (!hold_req) begin
            st <= S_RUN; hold_ack <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_arbiter_chk.sv
module ext_bus_arbiter_chk #(
  parameter int NREQ = 2,
  parameter int NCE  = 4,
  parameter int CEW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold_req,
  input logic            hold_mask,
  input logic            hold_ack,
  input logic [2:0]      cmd,
  input logic [CEW-1:0]  cmd_ce,
  input logic [NREQ-1:0] gnt
);
  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_RW = 3'd2,
                         K_DCA = 3'd3, K_REF = 3'd4, K_MRS = 3'd5;

  logic [NCE-1:0] opened;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opened <= '0;
    else if (cmd == K_DCA) opened <= '0;
    else if (cmd == K_ACT) opened[cmd_ce] <= 1'b1;
  end

  // R2
  rw_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RW) |-> opened[cmd_ce]);

  // R5
  dca_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_DCA) |=> (cmd == K_REF || cmd == K_MRS));

  // R7
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mask && !hold_ack) |=> !hold_ack);

  // R8
  ack_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> (cmd == K_REF && $past(cmd) == K_DCA));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && $past(hold_ack)) |-> (cmd == K_NOP && gnt == '0));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  // R11
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

bind ext_bus_arbiter ext_bus_arbiter_chk #(.NREQ(NREQ), .NCE(NCE), .CEW(CEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_mask(hold_mask),
  .hold_ack(hold_ack), .cmd(cmd), .cmd_ce(cmd_ce), .gnt(gnt));

// File: tb/tb_ext_bus_arbiter.sv
module tb_ext_bus_arbiter;
  localparam int CYC = 20;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req = '0;
  logic [3:0] req_ce = '0;
  logic [7:0] req_row = '0;
  logic       mode_req = 1'b0, hold_req = 1'b0, hold_mask = 1'b0;
  logic [9:0] ref_period = 10'd1000;
  logic [1:0] gnt;
  logic [2:0] cmd;
  logic [1:0] cmd_ce;
  logic [3:0] cmd_row;
  logic       hold_ack;
  int tests = 0, fails = 0;

  always #(CYC/2) clk = ~clk;

  ext_bus_arbiter dut (.clk(clk), .rst_n(rst_n), .req(req), .req_ce(req_ce), .req_row(req_row),
    .mode_req(mode_req), .hold_req(hold_req), .hold_mask(hold_mask), .ref_period(ref_period),
    .gnt(gnt), .cmd(cmd), .cmd_ce(cmd_ce), .cmd_row(cmd_row), .hold_ack(hold_ack));

  // {req0, ce[1:0], row[3:0], expected cmd[2:0]}
  localparam logic [9:0] VEC [9] = '{
    {1'b1, 2'd0, 4'd3, 3'd1}, {1'b1, 2'd0, 4'd3, 3'd2},
    {1'b1, 2'd0, 4'd5, 3'd1}, {1'b1, 2'd0, 4'd5, 3'd2},
    {1'b1, 2'd1, 4'd2, 3'd1}, {1'b1, 2'd1, 4'd2, 3'd2},
    {1'b1, 2'd0, 4'd5, 3'd2}, {1'b0, 2'd0, 4'd0, 3'd0},
    {1'b1, 2'd1, 4'd2, 3'd2}};

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; req = '0; req_ce = '0; req_row = '0;
    mode_req = 1'b0; hold_req = 1'b0; hold_mask = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int first, n, rws, refs;
    do_reset;
    // R12
    chk("R12 cmd", cmd, 0); chk("R12 gnt", gnt, 0); chk("R12 hold_ack", hold_ack, 0);

    // R1 table walk
    for (int i = 0; i < 9; i++) begin
      req[0] = VEC[i][9]; req_ce[1:0] = VEC[i][8:7]; req_row[3:0] = VEC[i][6:3];
      step;
      chk($sformatf("R1 vec%0d cmd", i), cmd, int'(VEC[i][2:0]));
    end

    // R6 / R2
    req = '0; mode_req = 1'b1; step; mode_req = 1'b0;
    step; chk("R6 close-all", cmd, 3);
    step; chk("R6 mode cmd", cmd, 5);
    req[0] = 1'b1; req_ce[1:0] = 2'd0; req_row[3:0] = 4'd5;
    step; chk("R2 activate after close-all", cmd, 1);
    step; chk("R2 rw after activate", cmd, 2);

    // R3 idle refresh interval
    do_reset; ref_period = 10'd20;
    first = 0;
    for (int k = 1; k <= 100 && first == 0; k++) begin step; if (cmd == 3'd4) first = k; end
    chk("R3 first refresh cycle", first, 22);
    n = 0;
    for (int k = 1; k <= 100 && n == 0; k++) begin step; if (cmd == 3'd4) n = k; end
    chk("R3 refresh interval", n, 22);

    // R4 urgent preemption of a busy owner
    do_reset; ref_period = 10'd20;
    req[0] = 1'b1; req_ce[1:0] = 2'd2; req_row[3:0] = 4'd1;
    first = 0;
    for (int k = 1; k <= 60 && first == 0; k++) begin step; if (cmd == 3'd3) first = k; end
    chk("R4 urgent close-all cycle", first, 41);
    step; chk("R4 refresh after close-all", cmd, 4);
    step; chk("R2 same row reactivated", cmd, 1);
    req = '0;

    // R11 priority and burst boundary
    do_reset; ref_period = 10'd1000;
    req = 2'b11; req_ce = {2'd3, 2'd0}; req_row = {4'd7, 4'd0};
    step; chk("R11 lower index wins", gnt, 1);
    do_reset;
    req[1] = 1'b1; req_ce[3:2] = 2'd3; req_row[7:4] = 4'd7;
    rws = 0;
    for (int k = 1; k <= 3; k++) begin step; if (cmd == 3'd2 && gnt == 2'b10) rws++; end
    req[0] = 1'b1; req_ce[1:0] = 2'd0; req_row[3:0] = 4'd0;
    n = 0;
    for (int k = 1; k <= 20 && n == 0; k++) begin
      step;
      if (gnt == 2'b01) n = 1;
      else if (cmd == 3'd2 && gnt == 2'b10) rws++;
    end
    chk("R11 burst length before yield", rws, 4);
    chk("R11 switch cmd", cmd, 1);

    // R7 masked hold, refresh continues
    do_reset; ref_period = 10'd20;
    hold_mask = 1'b1; hold_req = 1'b1;
    refs = 0; n = 0;
    for (int k = 1; k <= 70; k++) begin step; if (cmd == 3'd4) refs++; if (hold_ack) n++; end
    chk("R7 ack stays low", n, 0);
    chk("R7 refresh count", refs, 3);

    // R8 unmask while held
    hold_mask = 1'b0;
    step; chk("R8 close-all", cmd, 3); chk("R8 ack low", hold_ack, 0);
    step; chk("R8 refresh", cmd, 4); chk("R8 ack high", hold_ack, 1);

    // R9 quiet while held
    req[0] = 1'b1; req_ce[1:0] = 2'd1; req_row[3:0] = 4'd9;
    n = 0;
    for (int k = 0; k < 3; k++) begin step; if (cmd != 3'd0 || gnt != 2'b00 || !hold_ack) n++; end
    chk("R9 held cycles not quiet", n, 0);

    // R10 release
    hold_req = 1'b0;
    step; chk("R10 ack falls", hold_ack, 0);
    step; chk("R10 service resumes", cmd, 1); chk("R10 grant", gnt, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule